// File: doc/BRIEF.md
# Overcurrent Hiccup Supervisor

This block is the protection and supply-sequencing controller of an off-line flyback regulator. It has five states: power-down/charging, running, warning, fault-latched and drain-wait. It reads digital flags from the analog comparators and drives three outputs: permission to switch, the enable of the high-voltage start-up charger, and a gate pull-down.

An overcurrent flag on a single cycle is treated as a possible glitch. A second flagged cycle directly after it is taken as a real short. A confirmed fault, or a brownout, stops switching and stays latched until the supply sags below its undervoltage level. After that the charger stays off until the supply falls to the low protection-restart level. This produces a slow hiccup that puts little stress on the power stage.

In normal running the block also keeps the supply capacitor topped up. It does this during the switch off-time, with hysteresis between the restart level and the turn-on level.

Top module: `ocp_hiccup_supervisor`

## Requirements
- R1: While reset is low the block is in power-down: `sw_en`=0, `gate_pd`=1, and `chg_en` equals `bulk_ok`.
- R2: In power-down, `vcc_on` high at a clock edge moves the block to running. From the next cycle `sw_en`=1 and `gate_pd`=0. Switching is never granted without `vcc_on` in the previous cycle.
- R3: In running, `cyc_end` with `ocp_trip` (and no `brownout`) moves the block to warning. In warning, switching continues.
- R4: In warning, `cyc_end` without `ocp_trip` or `brownout` returns the block to running. A later single trip again only warns.
- R5: In warning, `cyc_end` with `ocp_trip` latches a fault. From the next cycle `sw_en`=0 and `gate_pd`=1.
- R6: `ocp_trip` and `brownout` are ignored in any cycle where `cyc_end` is low.
- R7: In running or warning, `cyc_end` with `brownout` latches a fault at once, the same as R5.
- R8: A latched fault holds `sw_en`=0 and `chg_en`=0 until `vcc_uvlo`. The block then waits with the charger off until `vcc_prot_low`, and returns to power-down/charging on the following edge.
- R9: In running or warning, `vcc_rst_low` at an edge sets a refill flag, and `vcc_on` at an edge clears it. `chg_en` = flag AND NOT `gate_on` AND `bulk_ok`.
- R10: `chg_en` is never high while `bulk_ok` is low.
- R11: While running or warning, `vcc_uvlo` forces `gate_pd`=1 and `sw_en`=0 in the same cycle, and returns the block to power-down on the next edge.
- R12: When `vcc_uvlo` and a fault condition arrive in the same running cycle, undervoltage wins and no fault latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_end | input | 1 | One-cycle strobe at switch turn-off |
| ocp_trip | input | 1 | Sense voltage crossed the hard 1 V level this cycle |
| brownout | input | 1 | Sense-pin source current too low during the on-time |
| gate_on | input | 1 | Power switch currently on |
| vcc_on | input | 1 | Supply above the turn-on level |
| vcc_uvlo | input | 1 | Supply below the undervoltage turn-off level |
| vcc_rst_low | input | 1 | Supply below the refill restart level |
| vcc_prot_low | input | 1 | Supply below the post-fault restart level |
| bulk_ok | input | 1 | Bulk input above the charger start level |
| sw_en | output | 1 | Switching permitted |
| chg_en | output | 1 | Start-up charger enable |
| gate_pd | output | 1 | Hold the gate low |

## Verification
The assertions assume that the supply flags are physically ordered. `vcc_on` is never high together with `vcc_uvlo`, `vcc_rst_low` or `vcc_prot_low`, and `vcc_prot_low` is only high while `vcc_uvlo` is high. They also assume `cyc_end` is a single-cycle strobe. The stimulus moves the supply flags in ramps that respect this ordering. It raises trips and brownout both on and off the strobe, so that the sampling rule and the priority rules are exercised.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [2:0] {
    ST_DOWN  = 3'd0,
    ST_RUN   = 3'd1,
    ST_WARN  = 3'd2,
    ST_LATCH = 3'd3,
    ST_DRAIN = 3'd4
  } supv_state_e;

  typedef struct packed {
    logic cyc_end;
    logic ocp_trip;
    logic brownout;
    logic vcc_on;
    logic vcc_uvlo;
    logic vcc_rst_low;
    logic vcc_prot_low;
  } supv_in_t;

  function automatic logic is_running(supv_state_e s);
    return (s == ST_RUN) || (s == ST_WARN);
  endfunction

  function automatic supv_state_e supv_next(supv_state_e s, supv_in_t i);
    supv_state_e n;
    n = s;
    case (s)
      ST_DOWN:  if (i.vcc_on) n = ST_RUN;
      ST_RUN: begin
        if (i.vcc_uvlo)                    n = ST_DOWN;
        else if (i.cyc_end && i.brownout)  n = ST_LATCH;
        else if (i.cyc_end && i.ocp_trip)  n = ST_WARN;
      end
      ST_WARN: begin
        if (i.vcc_uvlo)                                  n = ST_DOWN;
        else if (i.cyc_end && (i.ocp_trip || i.brownout)) n = ST_LATCH;
        else if (i.cyc_end)                              n = ST_RUN;
      end
      ST_LATCH: if (i.vcc_uvlo)     n = ST_DRAIN;
      ST_DRAIN: if (i.vcc_prot_low) n = ST_DOWN;
      default:  n = ST_DOWN;
    endcase
    return n;
  endfunction

  function automatic logic refill_next(logic running, logic q, logic rst_low, logic on);
    return running && (rst_low || (q && !on));
  endfunction
endpackage

// File: rtl/supv_fsm.sv
module supv_fsm
  import supv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  supv_in_t  flags,
  output logic      running,
  output logic      fault_hold,
  output logic      in_down,
  output logic      stop_evt,
  output logic      warn_evt
);
  supv_state_e st_q, st_d;

  always_comb st_d = supv_next(st_q, flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_DOWN;
    else        st_q <= st_d;
  end

  assign running    = is_running(st_q);
  assign fault_hold = (st_q == ST_LATCH) || (st_q == ST_DRAIN);
  assign in_down    = (st_q == ST_DOWN);
  assign stop_evt   = running && (st_d == ST_LATCH);
  assign warn_evt   = (st_q == ST_RUN) && (st_d == ST_WARN);
endmodule

// File: rtl/supv_refill.sv
module supv_refill
  import supv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic vcc_rst_low,
  input  logic vcc_on,
  output logic refill
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= refill_next(running, q, vcc_rst_low, vcc_on);
  end

  assign refill = q;
endmodule

// File: rtl/supv_drive.sv
module supv_drive (
  input  logic running,
  input  logic in_down,
  input  logic refill,
  input  logic gate_on,
  input  logic vcc_uvlo,
  input  logic bulk_ok,
  output logic sw_en,
  output logic chg_en,
  output logic gate_pd
);
  logic run_chg;

  assign run_chg = running && refill && !gate_on;
  assign sw_en   = running && !vcc_uvlo;
  assign gate_pd = !running || vcc_uvlo;
  assign chg_en  = bulk_ok && (in_down || run_chg);
endmodule

// File: rtl/ocp_hiccup_supervisor.sv
module ocp_hiccup_supervisor
  import supv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_end,
  input  logic ocp_trip,
  input  logic brownout,
  input  logic gate_on,
  input  logic vcc_on,
  input  logic vcc_uvlo,
  input  logic vcc_rst_low,
  input  logic vcc_prot_low,
  input  logic bulk_ok,
  output logic sw_en,
  output logic chg_en,
  output logic gate_pd
);
  supv_in_t flags;
  logic running, fault_hold, in_down, stop_evt, warn_evt, refill;

  always_comb begin
    flags.cyc_end      = cyc_end;
    flags.ocp_trip     = ocp_trip;
    flags.brownout     = brownout;
    flags.vcc_on       = vcc_on;
    flags.vcc_uvlo     = vcc_uvlo;
    flags.vcc_rst_low  = vcc_rst_low;
    flags.vcc_prot_low = vcc_prot_low;
  end

  supv_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .flags(flags),
    .running(running), .fault_hold(fault_hold), .in_down(in_down),
    .stop_evt(stop_evt), .warn_evt(warn_evt)
  );

  supv_refill u_refill (
    .clk(clk), .rst_n(rst_n), .running(running),
    .vcc_rst_low(vcc_rst_low), .vcc_on(vcc_on), .refill(refill)
  );

  supv_drive u_drive (
    .running(running), .in_down(in_down), .refill(refill), .gate_on(gate_on),
    .vcc_uvlo(vcc_uvlo), .bulk_ok(bulk_ok),
    .sw_en(sw_en), .chg_en(chg_en), .gate_pd(gate_pd)
  );
endmodule

// File: rtl/ocp_hiccup_supervisor_chk.sv
module ocp_hiccup_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic vcc_on,
  input logic vcc_uvlo,
  input logic bulk_ok,
  input logic gate_on,
  input logic sw_en,
  input logic chg_en,
  input logic gate_pd,
  input logic running,
  input logic fault_hold,
  input logic stop_evt,
  input logic warn_evt
);
  // R5
  confirm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sw_en && gate_pd));

  // R3
  warn_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_evt |=> running);

  // R8
  latch_no_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hold |-> (!chg_en && !sw_en));

  // R10
  bulk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |-> bulk_ok);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(vcc_on));

  // R9
  offtime_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && gate_on) |-> !chg_en);

  // R11
  uvlo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_uvlo && running) |=> !sw_en);
endmodule

bind ocp_hiccup_supervisor ocp_hiccup_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_on(vcc_on), .vcc_uvlo(vcc_uvlo),
  .bulk_ok(bulk_ok), .gate_on(gate_on), .sw_en(sw_en), .chg_en(chg_en),
  .gate_pd(gate_pd), .running(running), .fault_hold(fault_hold),
  .stop_evt(stop_evt), .warn_evt(warn_evt)
);

// File: tb/ocp_hiccup_supervisor_bench.sv
`timescale 1ns/1ps
module ocp_hiccup_supervisor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_end = 0, ocp_trip = 0, brownout = 0, gate_on = 0;
  logic vcc_on = 0, vcc_uvlo = 0, vcc_rst_low = 0, vcc_prot_low = 0, bulk_ok = 1;
  logic sw_en, chg_en, gate_pd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model: 0 down, 1 run, 2 warn, 3 latch, 4 drain
  int  m_mode = 0;
  bit  m_fill = 0;

  always #2 clk = ~clk;

  ocp_hiccup_supervisor u_ocp_hiccup_supervisor (
    .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .ocp_trip(ocp_trip),
    .brownout(brownout), .gate_on(gate_on), .vcc_on(vcc_on), .vcc_uvlo(vcc_uvlo),
    .vcc_rst_low(vcc_rst_low), .vcc_prot_low(vcc_prot_low), .bulk_ok(bulk_ok),
    .sw_en(sw_en), .chg_en(chg_en), .gate_pd(gate_pd)
  );

  task automatic cmp(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // inputs already set; compare, then clock, then update model
  task automatic step(string tag);
    bit live, e_sw, e_pd, e_chg;
    int nxt;
    #1;
    live  = (m_mode == 1) || (m_mode == 2);
    e_sw  = live && !vcc_uvlo;
    e_pd  = !e_sw;
    e_chg = bulk_ok && ((m_mode == 0) || (live && m_fill && !gate_on));
    cmp(tag, "sw_en", sw_en, e_sw);
    cmp(tag, "gate_pd", gate_pd, e_pd);
    cmp(tag, "chg_en", chg_en, e_chg);
    @(posedge clk);
    if (!rst_n) begin
      m_mode = 0; m_fill = 0;
    end else begin
      if (!live)             m_fill = 0;
      else if (vcc_rst_low)  m_fill = 1;
      else if (vcc_on)       m_fill = 0;
      nxt = m_mode;
      if (m_mode == 0 && vcc_on) nxt = 1;
      else if (live && vcc_uvlo) nxt = 0;
      else if (live && cyc_end) begin
        if (brownout)                      nxt = 3;
        else if (ocp_trip && m_mode == 2)  nxt = 3;
        else if (ocp_trip)                 nxt = 2;
        else                               nxt = 1;
      end
      else if (m_mode == 3 && vcc_uvlo)     nxt = 4;
      else if (m_mode == 4 && vcc_prot_low) nxt = 0;
      m_mode = nxt;
    end
    @(negedge clk);
  endtask

  task automatic strobe(string tag, logic trip, logic bo);
    gate_on = 1; step(tag);
    gate_on = 0; cyc_end = 1; ocp_trip = trip; brownout = bo; step(tag);
    cyc_end = 0; ocp_trip = 0; brownout = 0; step(tag);
  endtask

  task automatic power_up(string tag);
    vcc_prot_low = 0; vcc_uvlo = 0; vcc_rst_low = 0;
    step(tag);
    vcc_on = 1; step(tag);
    vcc_on = 0; step(tag);
  endtask

  initial begin
    @(negedge clk);
    for (int k = 0; k < 3; k++) step("R1");
    rst_n = 1;
    bulk_ok = 0; step("R10"); step("R10");
    bulk_ok = 1;
    power_up("R2");
    // trips without strobe
    ocp_trip = 1; gate_on = 1; step("R6"); gate_on = 0; step("R6");
    brownout = 1; step("R6"); ocp_trip = 0; brownout = 0; step("R6");
    strobe("R3", 1, 0);
    strobe("R4", 0, 0);
    strobe("R4", 1, 0);
    ocp_trip = 1; step("R6"); ocp_trip = 0; step("R6");
    strobe("R5", 1, 0);
    // latched: charger stays off
    vcc_rst_low = 1; step("R8"); step("R8");
    vcc_uvlo = 1; step("R8"); step("R8"); step("R8");
    vcc_prot_low = 1; step("R8"); step("R8");
    power_up("R8");
    // refill hysteresis
    vcc_rst_low = 1; gate_on = 1; step("R9"); gate_on = 0; step("R9");
    gate_on = 1; step("R9");
    vcc_rst_low = 0; gate_on = 0; step("R9"); step("R9");
    bulk_ok = 0; step("R10"); bulk_ok = 1; step("R9");
    vcc_on = 1; step("R9"); vcc_on = 0; step("R9"); step("R9");
    // brownout
    strobe("R7", 0, 1);
    vcc_uvlo = 1; step("R7"); vcc_prot_low = 1; step("R7"); step("R7");
    power_up("R7");
    // uvlo in run beats a trip
    strobe("R3", 1, 0);
    gate_on = 0; cyc_end = 1; ocp_trip = 1; vcc_uvlo = 1; step("R12");
    cyc_end = 0; ocp_trip = 0; step("R12"); step("R12");
    power_up("R11");
    vcc_uvlo = 1; step("R11"); step("R11");
    power_up("R2");
    for (int k = 0; k < 4; k++) strobe("R4", k[0], 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule